// File: doc/BRIEF.md
# Instruction Mix Profiling Counters

This block sits beside a single-cycle processor core and watches the instructions it retires. On every clock where the core reports a retired instruction, the profiler takes three control indications from that instruction: whether it writes the register file, whether it reads data memory and whether it writes data memory. From these it keeps three event counts: all retired instructions, instructions that write a register (loads and register-to-register operations), and instructions that touch memory (loads and stores).

Alongside the counts, the profiler sums a per-instruction clock-period cost for a variable-length clocking scheme. The cost is in percent of the base period. A full-length period is 100. An instruction that leaves memory alone saves 30, and one that writes no register saves 10. Loads therefore cost 100, stores 90, register-to-register operations 70, and branches and jumps 60. Software reads the counts and the sum and works out averages and speedup ratios itself.

All values are registered outputs, so they hold steady between clock edges. Every value saturates at its all-ones maximum instead of wrapping. A synchronous clear input zeroes all of them, and when the clear and a retired instruction fall in the same cycle, the clear wins.

Top module: `instr_mix_profiler`

## Requirements
- R1: While `rstN` is low at a rising clock edge, all four outputs become zero.
- R2: `instCount` increases by one on each rising edge where `instValid` is 1. It does not change on edges where `instValid` is 0, whatever the other inputs are.
- R3: `regWrCount` increases by one on each rising edge where `instValid` and `wrReg` are both 1.
- R4: `memCount` increases by one on each rising edge where `instValid` is 1 and at least one of `rdMem` or `wrMem` is 1.
- R5: On each rising edge where `instValid` is 1, `periodSum` increases by a cost. The cost starts at 100, drops by 30 when neither `rdMem` nor `wrMem` is 1, and drops by 10 when `wrReg` is 0. This gives 100 for a load, 90 for a store, 70 for a register-to-register operation and 60 for a branch or jump.
- R6: Every output saturates. A count at 2^CNT_W-1 stays there. If adding the cost would pass 2^ACC_W-1, `periodSum` becomes 2^ACC_W-1 instead.
- R7: When `clear` is 1 at a rising edge, all four outputs become zero, even if `instValid` is 1 in the same cycle.
- R8: The outputs change only at a rising clock edge. A change on any input between edges leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of all counters and the sum |
| instValid | input | 1 | An instruction retires this cycle |
| wrReg | input | 1 | The retiring instruction writes the register file |
| rdMem | input | 1 | The retiring instruction reads data memory |
| wrMem | input | 1 | The retiring instruction writes data memory |
| instCount | output | CNT_W (32) | Retired instruction count |
| regWrCount | output | CNT_W (32) | Register-writing instruction count |
| memCount | output | CNT_W (32) | Memory instruction count |
| periodSum | output | ACC_W (40) | Sum of per-instruction period costs, in percent |

## Verification
Two functions can fall in the same cycle: a clear and a counted retirement. The bench drives `clear` high together with `instValid` and mixed instruction kinds, and it expects all outputs to be zero on the next edge. The other overlap is saturation meeting a fresh increment. The bench runs with narrow counters and a narrow sum so that a long burst of loads pushes every value to its ceiling, and it then checks that the value stays at the ceiling while retirements keep arriving. A behavioural model in the bench tracks each value with plain integers and compares against it every cycle.

// File: rtl/profiler_pkg.sv
package profiler_pkg;

  // width of the per-instruction cost carried from control to datapath
  localparam int COST_W = 8;

  typedef struct packed {
    logic              clr;       // zero everything this edge
    logic              incInst;   // count a retired instruction
    logic              incRegWr;  // count a register-writing instruction
    logic              incMem;    // count a memory instruction
    logic [COST_W-1:0] cost;      // period cost in percent of base
  } profStrobe_t;

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     value
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W:0]   sum;
  logic [W-1:0] nextVal;

  always_comb begin
    sum     = {1'b0, value} + {{(W + 1 - INC_W){1'b0}}, inc};
    nextVal = sum[W] ? MAX_VAL : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) value <= '0;
    else if (en)      value <= nextVal;
  end

  // R7: a clear leaves zero behind
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (value == '0));

  // R6: without a clear the value never goes down (no wrap)
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> (value >= $past(value)));

  // R6: a value at its ceiling stays there
  assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && value == MAX_VAL) |=> (value == MAX_VAL));

  // R2: idle cycles leave the value alone
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !en) |=> $stable(value));

endmodule

// File: rtl/profiler_ctrl.sv
module profiler_ctrl
  import profiler_pkg::*;
#(
  parameter int BASE_COST  = 100,
  parameter int MEM_SAVE   = 30,
  parameter int REGWR_SAVE = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        instValid,
  input  logic        wrReg,
  input  logic        rdMem,
  input  logic        wrMem,
  output profStrobe_t strobe
);

  localparam int MIN_COST = BASE_COST - MEM_SAVE - REGWR_SAVE;

  logic memTouch;
  int   costInt;

  always_comb begin
    memTouch = rdMem | wrMem;
    costInt  = BASE_COST;
    if (!memTouch) costInt = costInt - MEM_SAVE;
    if (!wrReg)    costInt = costInt - REGWR_SAVE;
  end

  always_comb begin
    strobe.clr      = clear;
    strobe.incInst  = instValid && !clear;
    strobe.incRegWr = instValid && !clear && wrReg;
    strobe.incMem   = instValid && !clear && memTouch;
    strobe.cost     = COST_W'(costInt);
  end

  // R5: the cost handed to the datapath lies within the scheme's range
  assert_cost_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incInst |-> (int'(strobe.cost) >= MIN_COST && int'(strobe.cost) <= BASE_COST));

  // R7: the clear blocks every increment strobe
  assert_clear_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |-> !(strobe.incInst || strobe.incRegWr || strobe.incMem));

endmodule

// File: rtl/profiler_datapath.sv
module profiler_datapath
  import profiler_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  profStrobe_t      strobe,
  output logic [CNT_W-1:0] instCount,
  output logic [CNT_W-1:0] regWrCount,
  output logic [CNT_W-1:0] memCount,
  output logic [ACC_W-1:0] periodSum
);

  localparam int N_EVENTS = 3;

  logic [N_EVENTS-1:0] evEn;
  logic [CNT_W-1:0]    evVal [N_EVENTS];

  assign evEn = {strobe.incMem, strobe.incRegWr, strobe.incInst};

  for (genvar g = 0; g < N_EVENTS; g++) begin : g_event
    sat_counter #(.W(CNT_W), .INC_W(1)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strobe.clr),
      .en    (evEn[g]),
      .inc   (1'b1),
      .value (evVal[g])
    );
  end

  sat_counter #(.W(ACC_W), .INC_W(COST_W)) u_acc (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (strobe.clr),
    .en    (strobe.incInst),
    .inc   (strobe.cost),
    .value (periodSum)
  );

  assign instCount  = evVal[0];
  assign regWrCount = evVal[1];
  assign memCount   = evVal[2];

  // R3: register-writing instructions never outnumber all instructions
  assert_regwr_le_inst_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWrCount <= instCount);

  // R4: memory instructions never outnumber all instructions
  assert_mem_le_inst_R4: assert property (@(posedge clk) disable iff (!rstN)
    memCount <= instCount);

  // R2: the sum moves exactly when the instruction count is asked to
  assert_sum_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clr && !strobe.incInst) |=> $stable(periodSum));

endmodule

// File: rtl/instr_mix_profiler.sv
module instr_mix_profiler
  import profiler_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int ACC_W      = 40,
  parameter int BASE_COST  = 100,
  parameter int MEM_SAVE   = 30,
  parameter int REGWR_SAVE = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             instValid,
  input  logic             wrReg,
  input  logic             rdMem,
  input  logic             wrMem,
  output logic [CNT_W-1:0] instCount,
  output logic [CNT_W-1:0] regWrCount,
  output logic [CNT_W-1:0] memCount,
  output logic [ACC_W-1:0] periodSum
);

  initial begin
    assert_param_cost_R5: assert (BASE_COST < (1 << COST_W) && ACC_W > COST_W &&
                                   BASE_COST >= MEM_SAVE + REGWR_SAVE)
      else $error("profiler cost parameters out of range");
  end

  profStrobe_t strobe;

  profiler_ctrl #(
    .BASE_COST  (BASE_COST),
    .MEM_SAVE   (MEM_SAVE),
    .REGWR_SAVE (REGWR_SAVE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .instValid (instValid),
    .wrReg     (wrReg),
    .rdMem     (rdMem),
    .wrMem     (wrMem),
    .strobe    (strobe)
  );

  profiler_datapath #(
    .CNT_W (CNT_W),
    .ACC_W (ACC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instCount  (instCount),
    .regWrCount (regWrCount),
    .memCount   (memCount),
    .periodSum  (periodSum)
  );

endmodule

// File: tb/instr_mix_profiler_bench.sv
`timescale 1ns/1ps
module instr_mix_profiler_bench;

  localparam int CW = 8;
  localparam int AW = 12;
  localparam longint CMAX = (64'd1 << CW) - 1;
  localparam longint AMAX = (64'd1 << AW) - 1;

  logic clk = 0;
  logic rstN, clear, instValid, wrReg, rdMem, wrMem;
  logic [CW-1:0] instCount, regWrCount, memCount;
  logic [AW-1:0] periodSum;

  always #5 clk = ~clk;

  instr_mix_profiler #(.CNT_W(CW), .ACC_W(AW)) u_instr_mix_profiler (
    .clk(clk), .rstN(rstN), .clear(clear), .instValid(instValid),
    .wrReg(wrReg), .rdMem(rdMem), .wrMem(wrMem),
    .instCount(instCount), .regWrCount(regWrCount),
    .memCount(memCount), .periodSum(periodSum)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  longint mInst = 0, mReg = 0, mMem = 0, mSum = 0;

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(string ph);
    check({ph, " R2 instCount"},  longint'(instCount),  mInst);
    check({ph, " R3 regWrCount"}, longint'(regWrCount), mReg);
    check({ph, " R4 memCount"},   longint'(memCount),   mMem);
    check({ph, " R5 periodSum"},  longint'(periodSum),  mSum);
  endtask

  // kind: 0 load, 1 store, 2 reg-reg, 3 branch, 4 jump
  task automatic step(string ph, bit v, int kind, bit clr);
    longint cost;
    @(negedge clk);
    compareAll(ph);
    clear     = clr;
    instValid = v;
    wrReg     = (kind == 0 || kind == 2);
    rdMem     = (kind == 0);
    wrMem     = (kind == 1);
    #1;
    compareAll({ph, " R8 mid-cycle"});
    cost = 100;
    if (!(rdMem || wrMem)) cost -= 30;
    if (!wrReg) cost -= 10;
    if (clr) begin
      mInst = 0; mReg = 0; mMem = 0; mSum = 0;
    end else if (v) begin
      mInst = (mInst + 1 > CMAX) ? CMAX : mInst + 1;
      if (wrReg) mReg = (mReg + 1 > CMAX) ? CMAX : mReg + 1;
      if (rdMem || wrMem) mMem = (mMem + 1 > CMAX) ? CMAX : mMem + 1;
      mSum = (mSum + cost > AMAX) ? AMAX : mSum + cost;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; clear = 0; instValid = 0; wrReg = 1; rdMem = 1; wrMem = 1;
    repeat (3) @(negedge clk);
    compareAll("R1 reset");
    rstN = 1;

    // single kinds, expected cost per kind R5
    for (int k = 0; k < 5; k++) step("R5 kind", 1, k, 0);
    step("R2 idle", 0, 0, 0);
    step("R2 idle", 0, 2, 0);

    // mixed stream with idle gaps
    for (int i = 0; i < 60; i++) step("R2 mix", ($urandom % 4) != 0, $urandom % 5, 0);

    // clear colliding with a retirement R7
    step("R7 collide", 1, 0, 1);
    step("R7 after", 1, 1, 0);
    for (int i = 0; i < 20; i++) step("R7 mix", 1, $urandom % 5, ($urandom % 8) == 0);
    step("R7 collide", 1, 2, 1);

    // long burst of loads to reach every ceiling R6
    for (int i = 0; i < 300; i++) step("R6 sat", 1, (i % 7 == 3) ? 3 : 0, 0);
    for (int i = 0; i < 20; i++) step("R6 hold", 1, $urandom % 5, 0);
    step("R6 final", 0, 0, 0);
    check("R6 inst ceiling", longint'(instCount), CMAX);
    check("R6 sum ceiling",  longint'(periodSum), AMAX);

    step("R7 clear sat", 1, 0, 1);
    step("R7 zero", 0, 0, 0);
    check("R7 cleared inst", longint'(instCount), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule